// File: doc/BRIEF.md
# Supply Voltage Monitor Controller

This block is the digital side of a supply-voltage supervisor. An analog comparator outside the block compares the supply with a threshold that the block selects. The comparator returns one bit, which is high while the supply is below that threshold. Software programs the block through a small two-register interface. The control register holds an enable, a response-mode selector and a read-only status flag. The level register holds a 4-bit threshold code, which goes straight to the comparator.

When the block is enabled, it first waits a fixed number of cycles (`STAB_CYCLES`) so that the analog parts can settle. The comparator is ignored during this wait. After that, the comparator bit passes through a two-flop synchronizer and a glitch filter. The filtered value drives the status flag and one of two responses:

- **Interrupt mode (mode = 0):** a one-cycle interrupt pulse each time the supply falls below the threshold. An external mask input can block it.
- **Reset mode (mode = 1):** a level reset request that stays high while the supply is below the threshold.

Software normally polls the flag before it selects reset mode. Software stops the block either by writing zero to the control register, or by clearing the mode bit and then the enable bit.

The controller has four states, in `svm_fsm`:

- `MON_OFF`: the block is disabled.
- `MON_SETTLE`: the stabilization count is running.
- `MON_ABOVE`: the supply is at or above the threshold.
- `MON_BELOW`: the supply is below the threshold.

The transitions are:

- **enable:** `MON_OFF` to `MON_SETTLE`.
- **settle-done-high:** `MON_SETTLE` to `MON_ABOVE`.
- **settle-done-low:** `MON_SETTLE` to `MON_BELOW`.
- **drop:** `MON_ABOVE` to `MON_BELOW`.
- **recover:** `MON_BELOW` to `MON_ABOVE`.
- **disable:** from any state to `MON_OFF`.

Top module: `svm_ctrl`

## Requirements
- R1: After reset, both registers read 0, and `ready`, `irq` and `rst_req` are 0.
- R2: The control register is at `bus_addr` 0. Bit 7 is the enable, bit 1 selects reset mode, and bit 0 is the status flag. Writes to bit 0 are ignored, and bits 6..2 read 0. The level register is at `bus_addr` 1. Bits 3..0 hold the threshold code and appear on `lvl_sel`, and bits 7..4 read 0.
- R3: For `STAB_CYCLES` cycles after enable, `ready` is 0 and the comparator is ignored, so the flag reads 0. The number of cycles is counted from the cycle after the write.
- R4: Once `ready` is 1, the flag reads 1 when the filtered comparator reports the supply below the threshold, and 0 when the supply is at or above it.
- R5: A comparator change that lasts fewer than `FILT_LEN` cycles after the synchronizer has no effect on the flag or the outputs.
- R6: In interrupt mode with the mask at 0, `irq` gives exactly one single-cycle pulse on each entry into the below state. This includes entry at the end of stabilization.
- R7: While `irq_mask` is 1, `irq` stays 0.
- R8: In reset mode, `rst_req` is 1 while the supply is below the threshold. It returns to 0 once the supply recovers.
- R9: If reset mode is selected while the supply is already below the threshold, `rst_req` rises on the cycle after the write.
- R10: Writing 0 to the control register drops `rst_req` and `ready` by the next cycle. Clearing the mode bit first and the enable bit afterwards never raises `rst_req`.
- R11: In reset mode, no interrupt is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 is control, 1 is level |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_mask | input | 1 | Blocks the interrupt when 1 |
| cmp_below | input | 1 | Asynchronous comparator output; 1 means the supply is below the threshold |
| lvl_sel | output | 4 | Threshold code sent to the comparator |
| ready | output | 1 | Stabilization has finished and monitoring is active |
| irq | output | 1 | One-cycle interrupt pulse |
| rst_req | output | 1 | Internal reset request (level) |

## Verification
A wrong state would show at the ports within a few cycles, and each case has its own symptom:

- **Stuck in `MON_SETTLE`:** `ready` never rises after `STAB_CYCLES` plus one cycle.
- **Not leaving `MON_BELOW`:** the flag and `rst_req` stay high after the comparator has been low long enough to pass the synchronizer and filter, about `FILT_LEN` + 4 cycles.
- **Missed below-entry:** `irq` pulses are lost, which shows as an interrupt count that disagrees with the number of falling-supply steps.
- **Late disable:** a zero write leaves `rst_req` high on the following cycle.

// File: rtl/svm_pkg.sv
package svm_pkg;
    typedef enum logic [1:0] {
        MON_OFF    = 2'd0,
        MON_SETTLE = 2'd1,
        MON_ABOVE  = 2'd2,
        MON_BELOW  = 2'd3
    } mon_state_e;

    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_MODE_BIT = 1;
    localparam int CTRL_FLAG_BIT = 0;
    localparam int LVL_W         = 4;
    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_LVL    = 1'b1;
endpackage

// File: rtl/svm_regs.sv
module svm_regs
    import svm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             flag_in,
    output logic             en_q,
    output logic             mode_q,
    output logic [LVL_W-1:0] lvl_q,
    output logic [7:0]       bus_rdata
);
    logic unused_wdata;
    assign unused_wdata = &{1'b0, bus_wdata[6:LVL_W], bus_wdata[2], bus_wdata[CTRL_FLAG_BIT]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            lvl_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_CTRL) begin
                en_q   <= bus_wdata[CTRL_EN_BIT];
                mode_q <= bus_wdata[CTRL_MODE_BIT];
            end else begin
                lvl_q  <= bus_wdata[LVL_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CTRL_EN_BIT]   = en_q;
            bus_rdata[CTRL_MODE_BIT] = mode_q;
            bus_rdata[CTRL_FLAG_BIT] = flag_in;
        end else begin
            bus_rdata[LVL_W-1:0]     = lvl_q;
        end
    end
endmodule

// File: rtl/svm_sync_filter.sv
module svm_sync_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    output logic filt
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic          s1, s2;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= raw;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            filt    <= 1'b0;
            run_cnt <= '0;
        end else if (s2 != filt) begin
            if (run_cnt == CW'(FILT_LEN - 1)) begin
                filt    <= s2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end
endmodule

// File: rtl/svm_fsm.sv
module svm_fsm
    import svm_pkg::*;
#(
    parameter int STAB_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode,
    input  logic mask,
    input  logic below,
    output logic ready,
    output logic flag,
    output logic irq,
    output logic rst_req
);
    localparam int CW = $clog2(STAB_CYCLES + 1);

    mon_state_e    state, state_n;
    logic [CW-1:0] stab_cnt;
    logic          stab_done;
    logic          irq_q;

    assign stab_done = (stab_cnt == CW'(STAB_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MON_OFF;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (!en) begin
            state_n = MON_OFF;
        end else begin
            unique case (state)
                MON_OFF:    state_n = MON_SETTLE;
                MON_SETTLE: if (stab_done) state_n = below ? MON_BELOW : MON_ABOVE;
                MON_ABOVE:  if (below)     state_n = MON_BELOW;
                MON_BELOW:  if (!below)    state_n = MON_ABOVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab_cnt <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (state != MON_SETTLE)  stab_cnt <= '0;
            else if (!stab_done)      stab_cnt <= stab_cnt + 1'b1;
            irq_q <= (state_n == MON_BELOW) && (state != MON_BELOW) && !mode && !mask;
        end
    end

    always_comb begin
        ready   = en && ((state == MON_ABOVE) || (state == MON_BELOW));
        flag    = en && (state == MON_BELOW);
        rst_req = en && mode && (state == MON_BELOW);
        irq     = irq_q;
    end
endmodule

// File: rtl/svm_ctrl.sv
module svm_ctrl
    import svm_pkg::*;
#(
    parameter int STAB_CYCLES = 2000,
    parameter int FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             irq_mask,
    input  logic             cmp_below,
    output logic [LVL_W-1:0] lvl_sel,
    output logic             ready,
    output logic             irq,
    output logic             rst_req
);
    logic en_q, mode_q, flag_w, below_f;

    svm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .flag_in(flag_w), .en_q(en_q), .mode_q(mode_q),
        .lvl_q(lvl_sel), .bus_rdata(bus_rdata)
    );

    svm_sync_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .clr(!en_q), .raw(cmp_below), .filt(below_f)
    );

    svm_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .mask(irq_mask),
        .below(below_f), .ready(ready), .flag(flag_w), .irq(irq), .rst_req(rst_req)
    );
endmodule

// File: rtl/svm_ctrl_chk.sv
module svm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       irq_mask,
    input logic       ready,
    input logic       irq,
    input logic       rst_req
);
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(!irq_mask));

    p_reset_needs_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ready);

    p_no_irq_in_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req));

    p_zero_write_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_addr && !bus_wdata[7]) |=> (!ready && !rst_req));
endmodule

bind svm_ctrl svm_ctrl_chk u_chk (.*);

// File: tb/svm_ctrl_test.sv
`timescale 1ns/1ps
module svm_ctrl_test;
    localparam int STAB = 40;

    logic       clk = 0, rst_n = 0, bus_we = 0, bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic       irq_mask = 1, cmp_below = 0;
    logic [7:0] bus_rdata;
    logic [3:0] lvl_sel;
    logic       ready, irq, rst_req;

    int n_chk = 0, n_fail = 0, irq_cnt = 0, rst_cnt = 0;
    bit done = 0;

    svm_ctrl #(.STAB_CYCLES(STAB), .FILT_LEN(3)) uut (.*);

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (irq)     irq_cnt++;
        if (rst_req) rst_cnt++;
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0; bus_addr = 0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int flag_exp(bit lvl);
        return lvl ? 1 : 0;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base, exp_cnt, hold;
        bit prev, lvl;
        void'($urandom(32'd4242));
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(1);
        // R1 reset state
        check("R1", "ready", ready, 0);
        check("R1", "irq", irq, 0);
        check("R1", "rst_req", rst_req, 0);
        check("R1", "ctrl read", bus_rdata, 0);
        bus_addr = 1; #1;
        check("R1", "level read", bus_rdata, 0);
        bus_addr = 0;

        // R2 register layout
        wr(1, 8'hA5);
        check("R2", "lvl_sel", lvl_sel, 5);
        bus_addr = 1; #1;
        check("R2", "level readback", bus_rdata, 8'h05);
        bus_addr = 0; #1;
        wr(0, 8'h7F);
        check("R2", "ctrl readback", bus_rdata, 8'h02);
        wr(0, 8'h00);

        // R3 settle with comparator low-supply and mask set
        cmp_below = 1;
        wr(0, 8'h80);
        base = irq_cnt;
        wait_cyc(STAB - 2);
        check("R3", "ready during settle", ready, 0);
        check("R3", "flag during settle", bus_rdata[0], 0);
        wait_cyc(6);
        check("R3", "ready after settle", ready, 1);
        check("R4", "flag below", bus_rdata[0], 1);
        check("R7", "irq masked", irq_cnt - base, 0);

        // R4/R6 directed
        irq_mask = 0;
        cmp_below = 0; wait_cyc(12);
        check("R4", "flag above", bus_rdata[0], 0);
        base = irq_cnt;
        cmp_below = 1; wait_cyc(12);
        check("R6", "one irq on drop", irq_cnt - base, 1);
        // R5 glitch
        cmp_below = 0; wait_cyc(2); cmp_below = 1; wait_cyc(12);
        check("R5", "flag after short glitch", bus_rdata[0], 1);
        cmp_below = 0; wait_cyc(12);
        base = irq_cnt;
        cmp_below = 1; wait_cyc(1); cmp_below = 0; wait_cyc(12);
        check("R5", "irq after short dip", irq_cnt - base, 0);

        // R6/R4 random interrupt mode
        base = irq_cnt; exp_cnt = 0; prev = 0;
        for (int i = 0; i < 40; i++) begin
            lvl  = 1'($urandom_range(0, 1));
            hold = $urandom_range(10, 25);
            if (lvl && !prev) exp_cnt++;
            cmp_below = lvl;
            wait_cyc(hold);
            check("R4", "flag random", bus_rdata[0], flag_exp(lvl));
            prev = lvl;
        end
        check("R6", "irq count random", irq_cnt - base, exp_cnt);

        // R7 mask blocks drops
        cmp_below = 0; wait_cyc(12);
        irq_mask = 1; base = irq_cnt;
        cmp_below = 1; wait_cyc(12);
        check("R7", "masked drop", irq_cnt - base, 0);
        irq_mask = 0;

        // R9 reset mode while already below
        wr(0, 8'h82);
        check("R9", "rst_req immediate", rst_req, 1);

        // R8/R11 random reset mode
        base = irq_cnt;
        for (int i = 0; i < 30; i++) begin
            lvl  = 1'($urandom_range(0, 1));
            hold = $urandom_range(10, 25);
            cmp_below = lvl;
            wait_cyc(hold);
            check("R8", "rst_req follows supply", rst_req, flag_exp(lvl));
        end
        check("R11", "no irq in reset mode", irq_cnt - base, 0);

        // R10 ordered shutdown: mode first, then enable
        cmp_below = 1; wait_cyc(12);
        check("R8", "rst_req before shutdown", rst_req, 1);
        wr(0, 8'h80);
        base = rst_cnt;
        check("R10", "rst_req after mode clear", rst_req, 0);
        wr(0, 8'h00);
        wait_cyc(3);
        check("R10", "no spurious reset", rst_cnt - base, 0);
        check("R10", "ready after stop", ready, 0);

        // R10 zero write with reset active
        wr(0, 8'h80);
        wait_cyc(STAB + 10);
        wr(0, 8'h82);
        check("R9", "rst_req re-armed", rst_req, 1);
        wr(0, 8'h00);
        check("R10", "rst_req after zero write", rst_req, 0);
        check("R10", "ready after zero write", ready, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule